// File: doc/BRIEF.md
# Flash Controller Interrupt Unit

This unit collects the event signals of a flash controller and presents them to software in two views. A live status word mirrors the present levels of the sources, one clock late, including a two-bit count of corrected errors. An interrupt status word holds events that have happened since the last time it was read. A mask selects which of those held events drive a single active-high, level-sensitive interrupt line toward the system.

Each held bit is set when its source goes from low to high. A source that stays high does not set the bit again. Reading the interrupt status word returns its contents and empties it at the end of that cycle. If an event rises in the same cycle as that read, the event is not in the returned value but stays held for the next read. The readiness bits of the live word are meant for polling. Software that has seen a readiness interrupt can wait on the live bit until it settles.

A simple strobe bus reaches three registers: the live word, the interrupt word and the mask. Reads return data in the same cycle. Writes change only the mask.

Top module: `fc_irq_unit`

## Requirements
- R1: After reset the held events, the mask, the live word and the interrupt line are all zero.
- R2: The interrupt status word (address 1) and the mask (address 2) use one layout: bit 5 device ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault. Bits 7:6 read zero.
- R3: A held bit is set only at a clock edge where its source is high and was low at the previous edge. A source that stays high does not set the bit again after it has been cleared.
- R4: A read of address 1 returns the held bits in that cycle. All held bits are zero after the clock edge that ends the read, unless a new rise occurs at that edge.
- R5: A source that rises at the edge ending a read of address 1 is absent from that read's data and present in the next read.
- R6: The interrupt line is high in exactly the cycles in which some held bit is high and its mask bit is also high.
- R7: A write to address 2 loads the low six data bits into the mask. The mask reads back at address 2, and it keeps its value when no such write occurs.
- R8: The live word at address 0 shows, from one edge after the inputs: bit 6 decode failure, bits 5:4 the corrected count minus one, bit 3 errors detected (the decode error level), bit 2 ECC ready, bit 1 controller ready, bit 0 device ready. Bit 7 reads zero.
- R9: Writes to address 0 or address 1 change neither the mask, the held bits nor the live word.
- R10: Reads of address 0 or address 2 do not clear the held bits.
- R11: With no read strobe the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_dev_rdy | input | 1 | Flash device ready level |
| ev_ctl_rdy | input | 1 | Controller ready level |
| ev_dec_fail | input | 1 | Uncorrectable decode level |
| ev_dec_err | input | 1 | Errors detected by decoder level |
| ev_ecc_rdy | input | 1 | ECC result ready level |
| ev_wp_fault | input | 1 | Write-protect violation level |
| corr_cnt_m1 | input | CNT_W | Corrected error count minus one |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the read cycle |
| irq | output | 1 | Interrupt, active high, level |

## Verification
The hardest case to reach is a source that rises at the very edge that ends a read of the interrupt word. The clearing and the setting must then combine correctly, so the returned value excludes the new event and the next read includes it. The stimulus asserts the read strobe and raises a source in the same cycle, and it also holds a level high across several reads to show that no second set occurs. A random phase then mixes overlapping rises, reads at every address and mask writes. A behavioural model follows the unit on every cycle throughout.

// File: rtl/fc_irq_pkg.sv
package fc_irq_pkg;
   // held-event / mask bit positions
   localparam int IB_WPF   = 0;
   localparam int IB_ECC   = 1;
   localparam int IB_DERR  = 2;
   localparam int IB_DFAIL = 3;
   localparam int IB_CRDY  = 4;
   localparam int IB_DRDY  = 5;
   localparam int EV_N     = 6;
   // live word: fixed low fields, then count, then failure
   localparam int RAW_FIXED = 5;
endpackage

// File: rtl/fc_irq_latch.sv
module fc_irq_latch #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic         clr,
   output logic [N-1:0] lat
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic s_q;
         logic l_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= 1'b0;
               l_q <= 1'b0;
            end else begin
               s_q <= src[i];
               // clear and new rise combine: the rise wins
               l_q <= (l_q & ~clr) | (src[i] & ~s_q);
            end
         end
         assign lat[i] = l_q;
      end
   endgenerate
endmodule

// File: rtl/fc_irq_raw.sv
module fc_irq_raw #(
   parameter int CNT_W = 2,
   localparam int W    = fc_irq_pkg::RAW_FIXED + CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dev_rdy,
   input  logic             ctl_rdy,
   input  logic             ecc_rdy,
   input  logic             dec_err,
   input  logic             dec_fail,
   input  logic [CNT_W-1:0] cnt_m1,
   output logic [W-1:0]     raw_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= {dec_fail, cnt_m1, dec_err, ecc_rdy, ctl_rdy, dev_rdy};
   end
endmodule

// File: rtl/fc_irq_regs.sv
module fc_irq_regs #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int N      = 6,
   parameter int RAW_W  = 7,
   parameter logic [ADDR_W-1:0] A_RAW  = 0,
   parameter logic [ADDR_W-1:0] A_ISR  = 1,
   parameter logic [ADDR_W-1:0] A_MASK = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [RAW_W-1:0]  raw_q,
   input  logic [N-1:0]      lat,
   output logic [N-1:0]      mask_q,
   output logic              isr_clr,
   output logic [DATA_W-1:0] bus_rdata
);
   generate
      if (DATA_W < RAW_W || DATA_W < N) begin : g_bad_width
         $error("fc_irq_regs: data path narrower than a register");
      end
      if (DATA_W > N) begin : g_hi
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mask_q <= '0;
      else if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[N-1:0];
   end

   assign isr_clr = bus_rd && (bus_addr == A_ISR);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == A_RAW)       bus_rdata[RAW_W-1:0] = raw_q;
         else if (bus_addr == A_ISR)  bus_rdata[N-1:0]     = lat;
         else if (bus_addr == A_MASK) bus_rdata[N-1:0]     = mask_q;
      end
   end
endmodule

// File: rtl/fc_irq_unit.sv
module fc_irq_unit #(
   parameter int CNT_W  = 2,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_dev_rdy,
   input  logic              ev_ctl_rdy,
   input  logic              ev_dec_fail,
   input  logic              ev_dec_err,
   input  logic              ev_ecc_rdy,
   input  logic              ev_wp_fault,
   input  logic [CNT_W-1:0]  corr_cnt_m1,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import fc_irq_pkg::*;
   localparam int N     = EV_N;
   localparam int RAW_W = RAW_FIXED + CNT_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("fc_irq_unit: three registers need two address bits");
      end
   endgenerate

   logic [N-1:0]     src_vec;
   logic [N-1:0]     isr_q;
   logic [N-1:0]     mask_q;
   logic [RAW_W-1:0] raw_q;
   logic             isr_clr;

   always_comb begin
      src_vec           = '0;
      src_vec[IB_WPF]   = ev_wp_fault;
      src_vec[IB_ECC]   = ev_ecc_rdy;
      src_vec[IB_DERR]  = ev_dec_err;
      src_vec[IB_DFAIL] = ev_dec_fail;
      src_vec[IB_CRDY]  = ev_ctl_rdy;
      src_vec[IB_DRDY]  = ev_dev_rdy;
   end

   fc_irq_latch #(.N(N)) u_latch (
      .clk(clk), .rst_n(rst_n), .src(src_vec), .clr(isr_clr), .lat(isr_q)
   );

   fc_irq_raw #(.CNT_W(CNT_W)) u_raw (
      .clk(clk), .rst_n(rst_n),
      .dev_rdy(ev_dev_rdy), .ctl_rdy(ev_ctl_rdy), .ecc_rdy(ev_ecc_rdy),
      .dec_err(ev_dec_err), .dec_fail(ev_dec_fail), .cnt_m1(corr_cnt_m1),
      .raw_q(raw_q)
   );

   fc_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N), .RAW_W(RAW_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_q(raw_q), .lat(isr_q),
      .mask_q(mask_q), .isr_clr(isr_clr), .bus_rdata(bus_rdata)
   );

   assign irq = |(isr_q & mask_q);
endmodule

// File: rtl/fc_irq_chk.sv
module fc_irq_chk #(
   parameter int N      = 6,
   parameter int RAW_W  = 7,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [N-1:0]      src,
   input logic [N-1:0]      isr_q,
   input logic [N-1:0]      mask_q,
   input logic [RAW_W-1:0]  raw_q,
   input logic              irq
);
   // R3: a newly set held bit needs a rise of its source at that edge
   a_r3_set_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ((isr_q & ~$past(isr_q)) & ~($past(src) & ~$past(src, 2))) == '0);

   // R4: reading the interrupt word with no rise leaves it empty
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(1) && $stable(src)) |=> (isr_q == '0));

   // R6: no interrupt while everything is masked
   a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   // R6: interrupt implies a held event
   a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (isr_q != '0));

   // R7: mask changes only on a write to its address
   a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(2)) |=> $stable(mask_q));

   // R8: live device-ready bit follows its input one edge later
   a_r8_dev_live: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (raw_q[0] == $past(src[N-1])));
endmodule

bind fc_irq_unit fc_irq_chk #(.N(N), .RAW_W(RAW_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .src(src_vec), .isr_q(isr_q), .mask_q(mask_q),
   .raw_q(raw_q), .irq(irq)
);

// File: tb/fc_irq_unit_bench.sv
module fc_irq_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_dev_rdy = 0, ev_ctl_rdy = 0, ev_dec_fail = 0;
   logic       ev_dec_err = 0, ev_ecc_rdy = 0, ev_wp_fault = 0;
   logic [1:0] corr_cnt_m1 = 0;
   logic       bus_rd = 0, bus_wr = 0;
   logic [1:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   fc_irq_unit u_fc_irq_unit (
      .clk(clk), .rst_n(rst_n),
      .ev_dev_rdy(ev_dev_rdy), .ev_ctl_rdy(ev_ctl_rdy), .ev_dec_fail(ev_dec_fail),
      .ev_dec_err(ev_dec_err), .ev_ecc_rdy(ev_ecc_rdy), .ev_wp_fault(ev_wp_fault),
      .corr_cnt_m1(corr_cnt_m1), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference, updated at each rising edge
   bit [5:0] m_prev, m_lat, m_mask;
   bit [6:0] m_raw;
   always @(posedge clk) begin
      bit [5:0] s;
      s = {ev_dev_rdy, ev_ctl_rdy, ev_dec_fail, ev_dec_err, ev_ecc_rdy, ev_wp_fault};
      if (!rst_n) begin
         m_prev = 0; m_lat = 0; m_mask = 0; m_raw = 0;
      end else begin
         if (bus_rd && bus_addr == 2'd1) m_lat = 0;
         m_lat  = m_lat | (s & ~m_prev);
         m_prev = s;
         if (bus_wr && bus_addr == 2'd2) m_mask = bus_wdata[5:0];
         m_raw = {ev_dec_fail, corr_cnt_m1, ev_dec_err, ev_ecc_rdy, ev_ctl_rdy, ev_dev_rdy};
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_rd;
         chk(irq == |(m_lat & m_mask), "R6 irq", irq, |(m_lat & m_mask));
         exp_rd = 0;
         if (bus_rd) begin
            case (bus_addr)
               2'd0: exp_rd = m_raw;
               2'd1: exp_rd = m_lat;
               2'd2: exp_rd = m_mask;
               default: exp_rd = 0;
            endcase
         end
         chk(bus_rdata == exp_rd[7:0], bus_rd ? "R8/R4/R7 rdata" : "R11 idle rdata",
             bus_rdata, exp_rd);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic rd_exp(input logic [1:0] a, input logic [7:0] exp, input string tag);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      chk(bus_rdata == exp, tag, bus_rdata, exp);
      step();
      bus_rd = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      // R1 reset state
      @(negedge clk);
      chk(irq == 0, "R1 irq", irq, 0);
      step();
      rd_exp(0, 8'h00, "R1 raw");
      rd_exp(1, 8'h00, "R1 isr");
      rd_exp(2, 8'h00, "R1 mask");

      // R2 layout: ECC ready is bit 1
      ev_ecc_rdy = 1; step(); ev_ecc_rdy = 0;
      rd_exp(1, 8'h02, "R2 ecc bit");
      rd_exp(1, 8'h00, "R4 cleared");
      // R2: decode failure bit 3 with write-protect bit 0
      ev_dec_fail = 1; ev_wp_fault = 1; step(); ev_dec_fail = 0; ev_wp_fault = 0;
      rd_exp(1, 8'h09, "R2 fail+wp");
      ev_dev_rdy = 1; step(); ev_dev_rdy = 0; ev_ctl_rdy = 1; step(); ev_ctl_rdy = 0;
      rd_exp(1, 8'h30, "R2 ready bits");

      // R3: held level does not set again
      ev_dev_rdy = 1; step();
      rd_exp(1, 8'h20, "R3 first rise");
      repeat (3) step();
      rd_exp(1, 8'h00, "R3 level ignored");
      ev_dev_rdy = 0; step();

      // R5: rise at the edge that ends a read
      ev_wp_fault = 1; step(); ev_wp_fault = 0;
      bus_rd = 1; bus_addr = 2'd1; ev_ecc_rdy = 1;
      @(negedge clk);
      chk(bus_rdata == 8'h01, "R5 read excludes new", bus_rdata, 8'h01);
      step(); bus_rd = 0; ev_ecc_rdy = 0;
      rd_exp(1, 8'h02, "R5 new kept");

      // R6 masking
      wr(2, 8'h02);
      ev_wp_fault = 1; step(); ev_wp_fault = 0;
      @(negedge clk); chk(irq == 0, "R6 masked source", irq, 0);
      ev_ecc_rdy = 1; step(); ev_ecc_rdy = 0;
      @(negedge clk); chk(irq == 1, "R6 unmasked source", irq, 1);
      step();
      rd_exp(1, 8'h03, "R4 both held");
      @(negedge clk); chk(irq == 0, "R6 after clear", irq, 0);
      step();

      // R7 mask readback, upper bits dropped
      wr(2, 8'hFF);
      rd_exp(2, 8'h3F, "R7 mask readback");

      // R9 writes elsewhere ignored
      ev_ecc_rdy = 1; step(); ev_ecc_rdy = 0;
      wr(0, 8'hFF); wr(1, 8'h00); wr(3, 8'h00);
      rd_exp(2, 8'h3F, "R9 mask kept");
      rd_exp(0, 8'h00, "R9 raw kept");
      rd_exp(1, 8'h02, "R9 isr kept");

      // R8 live layout and R10 non-clearing reads
      corr_cnt_m1 = 2'b10; ev_dec_err = 1; ev_dec_fail = 1; ev_ctl_rdy = 1;
      step();
      rd_exp(0, 8'h6A, "R8 live word");
      rd_exp(0, 8'h6A, "R10 raw reread");
      rd_exp(2, 8'h3F, "R10 mask read");
      rd_exp(1, 8'h1C, "R10 isr intact");
      corr_cnt_m1 = 0; ev_dec_err = 0; ev_dec_fail = 0; ev_ctl_rdy = 0;
      step();
      rd_exp(0, 8'h00, "R8 live follows");

      // random mix, model compared every cycle
      for (int k = 0; k < 600; k++) begin
         logic [31:0] r;
         r = $urandom;
         ev_dev_rdy = r[0]; ev_ctl_rdy = r[1]; ev_dec_fail = r[2] & r[8];
         ev_dec_err = r[3]; ev_ecc_rdy = r[4]; ev_wp_fault = r[5] & r[9];
         corr_cnt_m1 = r[7:6];
         bus_rd = r[10] | r[11]; bus_addr = r[13:12];
         bus_wr = (r[15:14] == 2'b00); bus_wdata = r[23:16];
         step();
      end
      bus_rd = 0; bus_wr = 0;
      step(); step();
      finish_run();
   end
endmodule